// File: doc/BRIEF.md
# Exception Entry/Return Sequencer

This block saves and restores processor context around interrupts for a small microcontroller core. It latches interrupt requests as pending flags. When the core is in thread mode and a request is pending, the block writes an eight-word frame of registers below the active stack pointer. It then moves the core to handler mode on the main stack, places a return code in the link register and loads the program counter from a vector table. While it does this it holds a busy output high, and the core stalls until busy falls.

A handler needs no special instruction to finish. The block watches every branch target the core takes while idle, and a target that is one of the reserved return codes is never fetched. A valid code makes the block read the frame back from the stack that the code names. It restores the eight registers, steps that stack pointer back up, and sets mode and stack select from the code. The restored program counter is where execution resumes.

If a request is waiting at the moment of return, the block chains straight into the next handler. The frame stays on the stack and the stack pointer is not moved: only the vector is fetched and the link register is written again. Reserved codes that name the extended frame format, and values in the reserved range that are not codes, raise separate fault pulses and start nothing.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the block is idle with busy low and both fault outputs low. The core is in thread mode on the main stack, and the main and process stack pointers hold MSP_INIT and PSP_INIT.
- R2: A one-cycle pulse on a bit of irqReq sets a pending flag. An entry starts only in thread mode. In handler mode the flag stays pending and no memory traffic occurs. When several flags are pending, the lowest index is served first, and its flag is cleared when it is taken.
- R3: Entry writes eight words at addresses SP-32 to SP-4, in rising address order. The registers written are index 0, 1, 2, 3, 12, 14 (link), 15 (program counter) and 16 (status), in that order. The active stack pointer then becomes SP-32.
- R4: After the frame is written, handlerMode is 1 and procStack is 0.
- R5: Entry writes register 14 with 0xFFFFFFF9 if the process stack was not in use and with 0xFFFFFFFD if it was.
- R6: Entry and tail-chain read the word at VEC_BASE + 4*n for request n and write it to register 15.
- R7: A branch to 0xFFFFFFF1, 0xFFFFFFF9 or 0xFFFFFFFD with nothing pending reads eight words upward from the stack named by bit 2 (1 = process, 0 = main). Each word goes to the same register order as R3. That stack pointer then rises by 32, procStack takes bit 2, and handlerMode takes the inverse of bit 3.
- R8: The same branch with a request pending causes a tail-chain. It makes no stack writes and one memory read, leaves both stack pointers unchanged, writes the branched code to register 14, and ends in handler mode on the main stack.
- R9: A branch to 0xFFFFFFE1, 0xFFFFFFE9 or 0xFFFFFFED, where bit 4 is clear and so names the extended frame, raises faultFrame for exactly one cycle after the branch. It starts no memory access and changes no state.
- R10: Any other branch target from 0xFFFFFFE0 to 0xFFFFFFFF raises faultBadCode for exactly one cycle, with no memory access and no state change.
- R11: Branch targets below 0xFFFFFFE0 have no effect.
- R12: Each memory word is held on the port until memReady is seen. memReq is only high while busy. Busy is high from the cycle after a sequence is accepted until its last transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_IRQ | Interrupt request pulses |
| branchValid | input | 1 | Core took a branch this cycle |
| branchTarget | input | 32 | Target of that branch |
| rfRdAddr | output | 5 | Register-file read index during stacking |
| rfRdData | input | 32 | Register-file read data |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrAddr | output | 5 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| memReady | input | 1 | Memory accepts or returns the word this cycle |
| busy | output | 1 | Core stall during a sequence |
| handlerMode | output | 1 | 1 = handler mode |
| procStack | output | 1 | 1 = process stack active |
| msp | output | 32 | Main stack pointer |
| psp | output | 32 | Process stack pointer |
| faultBadCode | output | 1 | Illegal value in the return-code range |
| faultFrame | output | 1 | Extended-frame return code |

## Verification
The hardest state to reach is a tail-chain, which needs a request to sit pending at the exact idle cycle of a return branch. From the ports this works only because handler mode blocks new entries. The bench therefore raises two requests together while a handler runs, and checks that nothing happens. It then branches to a return code twice, which chains into each request in index order. A third branch unstacks the original frame. The process-stack path is reached by first unstacking a preloaded frame through the process-stack code, and stacking runs with a stalling memory so the hold behaviour is exercised.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_LRW,
    ST_VEC,
    ST_POP
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    seqState_e  state;
    logic [2:0] slot;
    logic       startEntry;
    logic       startChain;
    logic       startRet;
    logic       pushDone;
    logic       popDone;
    logic       flagBad;
    logic       flagExt;
  } seqCtl_t;

  localparam logic [4:0]  LR_IDX        = 5'd14;
  localparam logic [4:0]  PC_IDX        = 5'd15;
  localparam logic [31:0] FRAME_BYTES   = 32'd32;
  localparam logic [31:0] CODE_THR_MAIN = 32'hFFFF_FFF9;
  localparam logic [31:0] CODE_THR_PROC = 32'hFFFF_FFFD;

  // register index held in each frame slot, lowest address first
  function automatic logic [4:0] slotReg(input logic [2:0] s);
    case (s)
      3'd4:    slotReg = 5'd12;
      3'd5:    slotReg = LR_IDX;
      3'd6:    slotReg = PC_IDX;
      3'd7:    slotReg = 5'd16;
      default: slotReg = {2'b00, s};
    endcase
  endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    branchValid,
  input  logic    retHit,
  input  logic    retBad,
  input  logic    retExt,
  input  logic    pendAny,
  input  logic    inHandler,
  input  logic    memReady,
  output seqCtl_t ctl
);

  seqState_e stateQ, stateD;
  logic [2:0] slotQ, slotD;

  always_comb begin
    stateD         = stateQ;
    slotD          = slotQ;
    ctl            = '0;
    ctl.state      = stateQ;
    ctl.slot       = slotQ;
    case (stateQ)
      ST_IDLE: begin
        if (branchValid && retBad) begin
          ctl.flagBad = 1'b1;
        end else if (branchValid && retExt) begin
          ctl.flagExt = 1'b1;
        end else if (branchValid && retHit) begin
          if (pendAny) begin
            ctl.startChain = 1'b1;
            stateD         = ST_LRW;
          end else begin
            ctl.startRet = 1'b1;
            stateD       = ST_POP;
            slotD        = '0;
          end
        end else if (pendAny && !inHandler) begin
          ctl.startEntry = 1'b1;
          stateD         = ST_PUSH;
          slotD          = '0;
        end
      end
      ST_PUSH: begin
        if (memReady) begin
          slotD = slotQ + 3'd1;
          if (slotQ == 3'd7) begin
            ctl.pushDone = 1'b1;
            stateD       = ST_LRW;
          end
        end
      end
      ST_LRW: stateD = ST_VEC;
      ST_VEC: if (memReady) stateD = ST_IDLE;
      ST_POP: begin
        if (memReady) begin
          slotD = slotQ + 3'd1;
          if (slotQ == 3'd7) begin
            ctl.popDone = 1'b1;
            stateD      = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      slotQ  <= '0;
    end else begin
      stateQ <= stateD;
      slotQ  <= slotD;
    end
  end

endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 4,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000,
  parameter logic [31:0] MSP_INIT = 32'h0000_0200,
  parameter logic [31:0] PSP_INIT = 32'h0000_0300
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [31:0]        branchTarget,
  output logic               retHit,
  output logic               retBad,
  output logic               retExt,
  output logic               pendAny,
  output logic [4:0]         rfRdAddr,
  input  logic [31:0]        rfRdData,
  output logic               rfWrEn,
  output logic [4:0]         rfWrAddr,
  output logic [31:0]        rfWrData,
  output logic               memReq,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  input  logic [31:0]        memRdata,
  input  logic               memReady,
  output logic               handlerMode,
  output logic               procStack,
  output logic [31:0]        msp,
  output logic [31:0]        psp,
  output logic               faultBadCode,
  output logic               faultFrame
);

  localparam int unsigned IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] pendQ, takeMask;
  logic [IRQ_W-1:0]   pendSel, irqCurQ;
  logic [31:0]        codeQ, baseQ, mspQ, pspQ, activeSp, retSp, slotAddr, vecAddr;
  logic               handlerQ, procQ, badQ, extQ;
  logic               inWin, legalNib;

  // return-code window and decode
  assign inWin    = &branchTarget[31:5];
  assign legalNib = branchTarget[0] && !branchTarget[1] && !(branchTarget[2] && !branchTarget[3]);
  assign retHit   = inWin && legalNib && branchTarget[4];
  assign retExt   = inWin && legalNib && !branchTarget[4];
  assign retBad   = inWin && !legalNib;

  always_comb begin
    pendSel = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pendQ[i]) pendSel = IRQ_W'(i);
    end
  end

  assign pendAny  = |pendQ;
  assign takeMask = (ctl.startEntry || ctl.startChain) ? (NUM_IRQ'(1) << pendSel) : '0;
  assign activeSp = procQ ? pspQ : mspQ;
  assign retSp    = branchTarget[2] ? pspQ : mspQ;
  assign slotAddr = baseQ + {27'd0, ctl.slot, 2'b00};
  assign vecAddr  = VEC_BASE + {{(30 - IRQ_W){1'b0}}, irqCurQ, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      irqCurQ  <= '0;
      codeQ    <= '0;
      baseQ    <= '0;
      mspQ     <= MSP_INIT;
      pspQ     <= PSP_INIT;
      handlerQ <= 1'b0;
      procQ    <= 1'b0;
      badQ     <= 1'b0;
      extQ     <= 1'b0;
    end else begin
      pendQ <= (pendQ & ~takeMask) | irqReq;
      badQ  <= ctl.flagBad;
      extQ  <= ctl.flagExt;
      if (ctl.startEntry) begin
        baseQ   <= activeSp - FRAME_BYTES;
        codeQ   <= procQ ? CODE_THR_PROC : CODE_THR_MAIN;
        irqCurQ <= pendSel;
      end
      if (ctl.startChain) begin
        codeQ    <= branchTarget;
        irqCurQ  <= pendSel;
        handlerQ <= 1'b1;
        procQ    <= 1'b0;
      end
      if (ctl.startRet) begin
        baseQ <= retSp;
        codeQ <= branchTarget;
      end
      if (ctl.pushDone) begin
        if (procQ) pspQ <= baseQ;
        else       mspQ <= baseQ;
        procQ    <= 1'b0;
        handlerQ <= 1'b1;
      end
      if (ctl.popDone) begin
        if (codeQ[2]) pspQ <= baseQ + FRAME_BYTES;
        else          mspQ <= baseQ + FRAME_BYTES;
        procQ    <= codeQ[2];
        handlerQ <= !codeQ[3];
      end
    end
  end

  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = slotAddr;
    memWdata = rfRdData;
    rfRdAddr = slotReg(ctl.slot);
    rfWrEn   = 1'b0;
    rfWrAddr = slotReg(ctl.slot);
    rfWrData = memRdata;
    case (ctl.state)
      ST_PUSH: begin
        memReq = 1'b1;
        memWe  = 1'b1;
      end
      ST_LRW: begin
        rfWrEn   = 1'b1;
        rfWrAddr = LR_IDX;
        rfWrData = codeQ;
      end
      ST_VEC: begin
        memReq   = 1'b1;
        memAddr  = vecAddr;
        rfWrEn   = memReady;
        rfWrAddr = PC_IDX;
      end
      ST_POP: begin
        memReq = 1'b1;
        rfWrEn = memReady;
      end
      default: ;
    endcase
  end

  assign handlerMode  = handlerQ;
  assign procStack    = procQ;
  assign msp          = mspQ;
  assign psp          = pspQ;
  assign faultBadCode = badQ;
  assign faultFrame   = extQ;

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 4,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000,
  parameter logic [31:0] MSP_INIT = 32'h0000_0200,
  parameter logic [31:0] PSP_INIT = 32'h0000_0300
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               branchValid,
  input  logic [31:0]        branchTarget,
  output logic [4:0]         rfRdAddr,
  input  logic [31:0]        rfRdData,
  output logic               rfWrEn,
  output logic [4:0]         rfWrAddr,
  output logic [31:0]        rfWrData,
  output logic               memReq,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  input  logic [31:0]        memRdata,
  input  logic               memReady,
  output logic               busy,
  output logic               handlerMode,
  output logic               procStack,
  output logic [31:0]        msp,
  output logic [31:0]        psp,
  output logic               faultBadCode,
  output logic               faultFrame
);

  seqCtl_t ctl;
  logic    retHit, retBad, retExt, pendAny;

  exc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .branchValid (branchValid),
    .retHit      (retHit),
    .retBad      (retBad),
    .retExt      (retExt),
    .pendAny     (pendAny),
    .inHandler   (handlerMode),
    .memReady    (memReady),
    .ctl         (ctl)
  );

  exc_seq_dp #(
    .NUM_IRQ  (NUM_IRQ),
    .VEC_BASE (VEC_BASE),
    .MSP_INIT (MSP_INIT),
    .PSP_INIT (PSP_INIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .irqReq       (irqReq),
    .branchTarget (branchTarget),
    .retHit       (retHit),
    .retBad       (retBad),
    .retExt       (retExt),
    .pendAny      (pendAny),
    .rfRdAddr     (rfRdAddr),
    .rfRdData     (rfRdData),
    .rfWrEn       (rfWrEn),
    .rfWrAddr     (rfWrAddr),
    .rfWrData     (rfWrData),
    .memReq       (memReq),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memRdata     (memRdata),
    .memReady     (memReady),
    .handlerMode  (handlerMode),
    .procStack    (procStack),
    .msp          (msp),
    .psp          (psp),
    .faultBadCode (faultBadCode),
    .faultFrame   (faultFrame)
  );

  assign busy = (ctl.state != ST_IDLE);

endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memReady,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic        rfWrEn,
  input logic [4:0]  rfWrAddr,
  input logic        busy,
  input logic        handlerMode,
  input logic [31:0] msp,
  input logic [31:0] psp,
  input logic        faultBadCode,
  input logic        faultFrame
);

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy); // R12

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr))); // R12

  AST_NO_RF_WRITE_WHILE_STACKING: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !rfWrEn); // R3

  AST_MSP_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (msp != $past(msp)) |-> (msp == $past(msp) - 32'd32 || msp == $past(msp) + 32'd32)); // R3

  AST_PSP_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (psp != $past(psp)) |-> (psp == $past(psp) - 32'd32 || psp == $past(psp) + 32'd32)); // R7

  AST_LR_CODE_IN_HANDLER: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && rfWrAddr == 5'd14 && !memReq) |-> handlerMode); // R4

  AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({faultBadCode, faultFrame})); // R9

  AST_FAULT_STARTS_NOTHING: assert property (@(posedge clk) disable iff (!rstN)
    (faultBadCode || faultFrame) |-> !busy); // R10

endmodule

bind exc_frame_seq exc_frame_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .memReq       (memReq),
  .memReady     (memReady),
  .memWe        (memWe),
  .memAddr      (memAddr),
  .rfWrEn       (rfWrEn),
  .rfWrAddr     (rfWrAddr),
  .busy         (busy),
  .handlerMode  (handlerMode),
  .msp          (msp),
  .psp          (psp),
  .faultBadCode (faultBadCode),
  .faultFrame   (faultFrame)
);

// File: tb/exc_frame_seq_tb.sv
module exc_frame_seq_tb;

  localparam logic [31:0] MSP0 = 32'h0000_0200;
  localparam logic [31:0] PSP0 = 32'h0000_0300;
  localparam logic [31:0] VEC0 = 32'h0000_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic [3:0]  irqReq;
  logic        branchValid;
  logic [31:0] branchTarget;
  logic [4:0]  rfRdAddr, rfWrAddr;
  logic [31:0] rfRdData, rfWrData;
  logic        rfWrEn;
  logic        memReq, memWe, memReady;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        busy, handlerMode, procStack, faultBadCode, faultFrame;
  logic [31:0] msp, psp;

  logic [31:0] rf  [0:31];
  logic [31:0] mem [0:255];
  logic [31:0] wrAddr [0:63];
  logic [31:0] frameA [0:7];
  logic [31:0] frameB [0:7];
  int          wrCnt, rdCnt, checks, fails, cyc;
  logic        stallOn, reqOutside, busyEarly;
  logic [1:0]  rdyCnt;

  exc_frame_seq #(
    .NUM_IRQ (4), .VEC_BASE (VEC0), .MSP_INIT (MSP0), .PSP_INIT (PSP0)
  ) u_dut (
    .clk (clk), .rstN (rstN), .irqReq (irqReq),
    .branchValid (branchValid), .branchTarget (branchTarget),
    .rfRdAddr (rfRdAddr), .rfRdData (rfRdData),
    .rfWrEn (rfWrEn), .rfWrAddr (rfWrAddr), .rfWrData (rfWrData),
    .memReq (memReq), .memWe (memWe), .memAddr (memAddr),
    .memWdata (memWdata), .memRdata (memRdata), .memReady (memReady),
    .busy (busy), .handlerMode (handlerMode), .procStack (procStack),
    .msp (msp), .psp (psp),
    .faultBadCode (faultBadCode), .faultFrame (faultFrame)
  );

  assign rfRdData = rf[rfRdAddr];
  assign memRdata = mem[memAddr[9:2]];
  assign memReady = !stallOn || rdyCnt[0];

  // core and memory models
  always @(posedge clk) begin
    rdyCnt <= rdyCnt + 2'd1;
    if (rfWrEn) rf[rfWrAddr] <= rfWrData;
    if (memReq && memReady) begin
      if (memWe) begin
        mem[memAddr[9:2]] <= memWdata;
        wrAddr[wrCnt[5:0]] <= memAddr;
        wrCnt <= wrCnt + 1;
      end else begin
        rdCnt <= rdCnt + 1;
      end
    end
    if (rstN && memReq && !busy) reqOutside <= 1'b1;
  end

  function automatic int sreg(input int k);
    case (k)
      4: sreg = 12;
      5: sreg = 14;
      6: sreg = 15;
      7: sreg = 16;
      default: sreg = k;
    endcase
  endfunction

  function automatic logic [31:0] vec(input int n);
    vec = 32'h0800_0100 + 32'(n * 16);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    wrCnt = 0;
    rdCnt = 0;
  endtask

  task automatic pulseIrq(input logic [3:0] mask);
    @(negedge clk) irqReq = mask;
    @(negedge clk) irqReq = '0;
    @(negedge clk);
    busyEarly = busy;
    waitIdle();
  endtask

  // drives one branch; at return, registered fault outputs for it are visible
  task automatic branch(input logic [31:0] tgt);
    @(negedge clk);
    branchValid  = 1'b1;
    branchTarget = tgt;
    @(negedge clk);
    branchValid  = 1'b0;
    branchTarget = '0;
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 handlerMode", {31'd0, handlerMode}, 32'd0);
    chk("R1 procStack", {31'd0, procStack}, 32'd0);
    chk("R1 msp", msp, MSP0);
    chk("R1 psp", psp, PSP0);
    chk("R1 faults", {30'd0, faultBadCode, faultFrame}, 32'd0);
  endtask

  task automatic t_ignoreBranch();
    clearLog();
    branch(32'h0000_0100);
    chk("R11 no busy", {31'd0, busy}, 32'd0);
    branch(32'hFFFF_FF1F);
    chk("R11 no fault", {30'd0, faultBadCode, faultFrame}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R11 no traffic", 32'(wrCnt + rdCnt), 32'd0);
    chk("R11 mode kept", {30'd0, handlerMode, procStack}, 32'd0);
  endtask

  task automatic t_entryMain();
    for (int k = 0; k < 8; k++) begin
      rf[sreg(k)] = 32'h1000_0000 + 32'(k * 32'h11);
      frameA[k]   = rf[sreg(k)];
    end
    stallOn = 1'b1;
    clearLog();
    pulseIrq(4'b0100);
    stallOn = 1'b0;
    chk("R12 busy after accept", {31'd0, busyEarly}, 32'd1);
    chk("R3 write count", 32'(wrCnt), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk("R3 frame address", wrAddr[k], MSP0 - 32'd32 + 32'(4 * k));
      chk("R3 frame word", mem[((MSP0 - 32'd32) >> 2) + 32'(k)], frameA[k]);
    end
    chk("R3 msp", msp, MSP0 - 32'd32);
    chk("R4 handler", {30'd0, handlerMode, procStack}, 32'd2);
    chk("R5 lr code main", rf[14], 32'hFFFF_FFF9);
    chk("R6 vector irq2", rf[15], vec(2));
    chk("R6 one read", 32'(rdCnt), 32'd1);
  endtask

  task automatic t_pendInHandler();
    clearLog();
    @(negedge clk) irqReq = 4'b1010;
    @(negedge clk) irqReq = '0;
    repeat (5) @(negedge clk);
    chk("R2 held in handler busy", {31'd0, busy}, 32'd0);
    chk("R2 held in handler traffic", 32'(wrCnt + rdCnt), 32'd0);
  endtask

  task automatic t_tailChain();
    clearLog();
    branch(32'hFFFF_FFF9);
    waitIdle();
    chk("R8 chain no writes", 32'(wrCnt), 32'd0);
    chk("R8 chain one read", 32'(rdCnt), 32'd1);
    chk("R2 lowest first", rf[15], vec(1));
    chk("R8 lr code", rf[14], 32'hFFFF_FFF9);
    chk("R8 msp unchanged", msp, MSP0 - 32'd32);
    chk("R8 handler main", {30'd0, handlerMode, procStack}, 32'd2);
    clearLog();
    branch(32'hFFFF_FFF9);
    waitIdle();
    chk("R2 second pending", rf[15], vec(3));
    chk("R8 second chain traffic", 32'(wrCnt + rdCnt), 32'd1);
  endtask

  task automatic t_returnMain();
    clearLog();
    branch(32'hFFFF_FFF9);
    waitIdle();
    chk("R7 read count", 32'(rdCnt), 32'd8);
    for (int k = 0; k < 8; k++) chk("R7 restored reg", rf[sreg(k)], frameA[k]);
    chk("R7 msp", msp, MSP0);
    chk("R7 thread main", {30'd0, handlerMode, procStack}, 32'd0);
  endtask

  task automatic t_processStack();
    for (int k = 0; k < 8; k++) mem[(PSP0 >> 2) + 32'(k)] = 32'h5000_0000 + 32'(k);
    clearLog();
    branch(32'hFFFF_FFFD);
    waitIdle();
    for (int k = 0; k < 8; k++) chk("R7 psp frame reg", rf[sreg(k)], 32'h5000_0000 + 32'(k));
    chk("R7 psp up", psp, PSP0 + 32'd32);
    chk("R7 thread process", {30'd0, handlerMode, procStack}, 32'd1);
    for (int k = 0; k < 8; k++) frameB[k] = rf[sreg(k)];
    clearLog();
    pulseIrq(4'b0001);
    chk("R3 psp down", psp, PSP0);
    chk("R3 msp kept", msp, MSP0);
    chk("R3 psp frame addr", wrAddr[0], PSP0);
    chk("R3 psp frame word", mem[(PSP0 >> 2) + 32'd6], frameB[6]);
    chk("R5 lr code process", rf[14], 32'hFFFF_FFFD);
    chk("R6 vector irq0", rf[15], vec(0));
    chk("R4 main after entry", {30'd0, handlerMode, procStack}, 32'd2);
    branch(32'hFFFF_FFFD);
    waitIdle();
    chk("R7 psp return", psp, PSP0 + 32'd32);
    chk("R7 psp return pc", rf[15], frameB[6]);
  endtask

  task automatic t_extFrame();
    clearLog();
    branch(32'hFFFF_FFE9);
    chk("R9 faultFrame", {30'd0, faultBadCode, faultFrame}, 32'd1);
    chk("R9 no busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R9 one cycle", {31'd0, faultFrame}, 32'd0);
    chk("R9 no traffic", 32'(wrCnt + rdCnt), 32'd0);
    chk("R9 psp kept", psp, PSP0 + 32'd32);
  endtask

  task automatic t_badCode();
    clearLog();
    branch(32'hFFFF_FFF5);
    chk("R10 fault F5", {30'd0, faultBadCode, faultFrame}, 32'd2);
    branch(32'hFFFF_FFE0);
    chk("R10 fault E0", {30'd0, faultBadCode, faultFrame}, 32'd2);
    @(negedge clk);
    chk("R10 one cycle", {31'd0, faultBadCode}, 32'd0);
    chk("R10 no traffic", 32'(wrCnt + rdCnt), 32'd0);
    chk("R10 mode kept", {30'd0, handlerMode, procStack}, 32'd1);
    chk("R12 req only busy", {31'd0, reqOutside}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; wrCnt = 0; rdCnt = 0;
    rdyCnt = '0; stallOn = 1'b0; reqOutside = 1'b0; busyEarly = 1'b0;
    irqReq = '0; branchValid = 1'b0; branchTarget = '0; rstN = 1'b0;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) wrAddr[i] = '0;
    for (int n = 0; n < 4; n++) mem[(VEC0 >> 2) + 32'(n)] = vec(n);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignoreBranch();
    t_entryMain();
    t_pendInHandler();
    t_tailChain();
    t_returnMain();
    t_processStack();
    t_extFrame();
    t_badCode();
    summary();
    $finish;
  end

endmodule